// File: doc/BRIEF.md
# Hibernate Wakeup and Reset Sequencer

This block manages power on the slow real-time clock domain, where every clock cycle is one tick. Software puts the system to sleep by writing to a command register. The block then drops its power-enable output and waits for an external active-low wake pin. A press counts as a wakeup only when the pin has stayed low for a programmable number of ticks. Any bounce sends the block back to sleep, and the qualification starts again from zero.

Once a wakeup is accepted, power is restored at once. The system reset output stays low for a second programmable number of ticks and is then released, and the block returns to normal operation. Both durations use a coarse step of 32 ticks, because the low five bits of each register are not implemented. A small word-addressed register port lets software set the two durations, issue the sleep command and read whether the block is out of its running state.

Top module: `hib_wake_seq`

## Requirements
- R1: After reset `pwr_en` and `sys_rst_n` are 1. The filter register at 0x24 reads 3264, the hold register at 0x28 reads 1952, and the command register at 0x20 reads 0.
- R2: A write to 0x20 with data bit 0 set, while running, drops `pwr_en` and `sys_rst_n` after that clock edge, and 0x20 then reads 1. The same write with bit 0 clear has no effect.
- R3: The filter register keeps only data bits 15:5. Every other bit reads 0 whatever was written.
- R4: The hold register keeps only data bits 11:5. Every other bit reads 0 whatever was written.
- R5: A read of any address other than 0x20, 0x24 or 0x28 returns 0.
- R6: While asleep with filter value F, number the first clock edge at which `wake_n` is sampled low as edge 0. If the pin then stays low, `pwr_en` returns to 1 just after edge F+3, while `sys_rst_n` is still 0.
- R7: If `wake_n` goes high before the filter count completes, the block falls back to sleep with `pwr_en` at 0. A later wakeup needs the full F+3 edges again.
- R8: With hold value H, `sys_rst_n` rises max(H,1) edges after `pwr_en` returns, and 0x20 then reads 0.
- R9: Filter and hold values of 0 give the shortest sequence. Power returns after edge 3, and the reset is released one edge later.
- R10: `pwr_en` never falls except at the edge that follows an accepted sleep command. `sys_rst_n` never rises unless power was already on in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock, one tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Register byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| wake_n | input | 1 | External wake pin, active low, asynchronous |
| pwr_en | output | 1 | Power enable to the switched domain |
| sys_rst_n | output | 1 | System reset, active low |

## Verification
The hardest case to reach is a bounce on the wake pin that arrives partway through the filter count. The stimulus has to put the block to sleep and hold the pin low for fewer ticks than the programmed filter. It then releases the pin and, well after a wakeup would have completed, confirms that power is still off and the command register still reads 1. A second, unbroken press must then take exactly F+3 edges again, which shows the count really restarted. Edge exactness is checked by counting clock edges from the first low sample, for a mid-range setting, for the zero setting and for the reset defaults.

// File: rtl/hib_wake_seq.sv
module hib_wake_seq #(
  parameter int ADDR_W    = 6,
  parameter int FILT_W    = 16,
  parameter int HOLD_W    = 12,
  parameter int STEP_LSB  = 5,
  parameter int FILT_INIT = 3264,
  parameter int HOLD_INIT = 1952,
  parameter logic [ADDR_W-1:0] CMD_ADDR  = 6'h20,
  parameter logic [ADDR_W-1:0] FILT_ADDR = 6'h24,
  parameter logic [ADDR_W-1:0] HOLD_ADDR = 6'h28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              wake_n,
  output logic              pwr_en,
  output logic              sys_rst_n
);

  localparam int CNT_W = (FILT_W > HOLD_W) ? FILT_W : HOLD_W;
  localparam logic [FILT_W-1:0] FILT_MASK = {{(FILT_W-STEP_LSB){1'b1}}, {STEP_LSB{1'b0}}};
  localparam logic [HOLD_W-1:0] HOLD_MASK = {{(HOLD_W-STEP_LSB){1'b1}}, {STEP_LSB{1'b0}}};

  typedef enum logic [1:0] {S_RUN, S_SLEEP, S_QUAL, S_HOLD} st_t;

  st_t              st, st_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic [FILT_W-1:0] filt_q;
  logic [HOLD_W-1:0] hold_q;
  logic             pin_s1, pin_s2;
  logic             pin_low, sleep_cmd, qual_done, hold_done;
  logic             unused_wd;

  assign unused_wd = ^{wdata[31:FILT_W], wdata[STEP_LSB-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_s1 <= 1'b1;
      pin_s2 <= 1'b1;
    end else begin
      pin_s1 <= wake_n;
      pin_s2 <= pin_s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q <= FILT_W'(FILT_INIT) & FILT_MASK;
      hold_q <= HOLD_W'(HOLD_INIT) & HOLD_MASK;
    end else if (wr_en) begin
      if (addr == FILT_ADDR) filt_q <= wdata[FILT_W-1:0] & FILT_MASK;
      if (addr == HOLD_ADDR) hold_q <= wdata[HOLD_W-1:0] & HOLD_MASK;
    end
  end

  assign pin_low   = !pin_s2;
  assign sleep_cmd = wr_en && (addr == CMD_ADDR) && wdata[0];
  assign qual_done = cnt >= CNT_W'(filt_q);
  assign hold_done = ({1'b0, cnt} + 1'b1) >= (CNT_W+1)'(hold_q);

  always_comb begin
    st_n  = st;
    cnt_n = cnt;
    case (st)
      S_RUN:   if (sleep_cmd) st_n = S_SLEEP;
      S_SLEEP: if (pin_low) begin
                 st_n  = S_QUAL;
                 cnt_n = '0;
               end
      S_QUAL:  if (!pin_low) st_n = S_SLEEP;
               else if (qual_done) begin
                 st_n  = S_HOLD;
                 cnt_n = '0;
               end else cnt_n = cnt + 1'b1;
      S_HOLD:  if (hold_done) st_n = S_RUN;
               else cnt_n = cnt + 1'b1;
      default: st_n = S_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_RUN;
      cnt <= '0;
    end else begin
      st  <= st_n;
      cnt <= cnt_n;
    end
  end

  assign pwr_en    = (st == S_RUN) || (st == S_HOLD);
  assign sys_rst_n = (st == S_RUN);

  always_comb begin
    rdata = '0;
    if (addr == CMD_ADDR)       rdata[0] = (st != S_RUN);
    else if (addr == FILT_ADDR) rdata[FILT_W-1:0] = filt_q;
    else if (addr == HOLD_ADDR) rdata[HOLD_W-1:0] = hold_q;
  end

endmodule

// File: rtl/hib_wake_seq_chk.sv
module hib_wake_seq_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic [31:0]       rdata,
  input logic              pwr_en,
  input logic              sys_rst_n
);

  // R10
  power_drop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_en) |-> $past(wr_en && addr == 6'h20 && wdata[0]));

  // R10
  reset_release_powered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_n) |-> (pwr_en && $past(pwr_en)));

  // R6
  power_back_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_en) |-> !sys_rst_n);

  // R8
  hold_keeps_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_en && !sys_rst_n) |=> pwr_en);

  // R3
  filt_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 6'h24) |-> (rdata[31:16] == 16'h0 && rdata[4:0] == 5'h0));

  // R4
  hold_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 6'h28) |-> (rdata[31:12] == 20'h0 && rdata[4:0] == 5'h0));

endmodule

bind hib_wake_seq hib_wake_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .pwr_en(pwr_en), .sys_rst_n(sys_rst_n)
);

// File: tb/sim_hib_wake_seq.sv
`timescale 1ns/1ps
module sim_hib_wake_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  addr = 6'h0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        wake_n = 1'b1;
  logic        pwr_en, sys_rst_n;
  int          n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  hib_wake_seq u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .wake_n(wake_n), .pwr_en(pwr_en), .sys_rst_n(sys_rst_n)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd_chk(input string tag, input logic [5:0] a, input logic [31:0] exp);
    @(negedge clk);
    addr = a;
    #1 chk(tag, rdata, exp);
  endtask

  task automatic go_sleep(input string tag);
    wr(6'h20, 32'h1);
    chk({tag, " pwr_en"}, {31'b0, pwr_en}, 32'h0);
    chk({tag, " sys_rst_n"}, {31'b0, sys_rst_n}, 32'h0);
  endtask

  task automatic wake_measure(input string tag, input int f, input int h);
    int n = 0;
    int m = 0;
    @(negedge clk);
    wake_n = 1'b0;
    do begin @(negedge clk); n++; end while (!pwr_en && n < 70000);
    chk({tag, " R6 power edge"}, n, f + 4);
    chk({tag, " R6 reset still low"}, {31'b0, sys_rst_n}, 32'h0);
    do begin @(negedge clk); m++; end while (!sys_rst_n && m < 70000);
    chk({tag, " R8 hold edges"}, m, (h < 1) ? 1 : h);
    wake_n = 1'b1;
    rd_chk({tag, " R8 running"}, 6'h20, 32'h0);
  endtask

  task automatic t_reset;
    chk("R1 pwr_en", {31'b0, pwr_en}, 32'h1);
    chk("R1 sys_rst_n", {31'b0, sys_rst_n}, 32'h1);
    rd_chk("R1 filter", 6'h24, 32'd3264);
    rd_chk("R1 hold", 6'h28, 32'd1952);
    rd_chk("R1 cmd", 6'h20, 32'h0);
  endtask

  task automatic t_regs;
    wr(6'h24, 32'hFFFF_FFFF);
    rd_chk("R3 filter mask", 6'h24, 32'h0000_FFE0);
    wr(6'h28, 32'hFFFF_FFFF);
    rd_chk("R4 hold mask", 6'h28, 32'h0000_0FE0);
    rd_chk("R5 unmapped 0x2C", 6'h2C, 32'h0);
    rd_chk("R5 unmapped 0x00", 6'h00, 32'h0);
    wr(6'h20, 32'hFFFF_FFFE);
    chk("R2 bit0 clear ignored", {31'b0, pwr_en}, 32'h1);
    rd_chk("R2 bit0 clear cmd", 6'h20, 32'h0);
  endtask

  task automatic t_mid;
    wr(6'h24, 32'd32);
    wr(6'h28, 32'd64);
    go_sleep("R2 mid");
    rd_chk("R2 cmd reads 1", 6'h20, 32'h1);
    repeat (10) @(negedge clk);
    chk("R2 stays asleep", {31'b0, pwr_en}, 32'h0);
    wake_measure("mid", 32, 64);
  endtask

  task automatic t_zero;
    wr(6'h24, 32'h1F);
    rd_chk("R9 filter low bits drop", 6'h24, 32'h0);
    wr(6'h28, 32'h1F);
    rd_chk("R9 hold low bits drop", 6'h28, 32'h0);
    go_sleep("R9 zero");
    wake_measure("R9 zero", 0, 0);
  endtask

  task automatic t_bounce;
    wr(6'h24, 32'd64);
    wr(6'h28, 32'd32);
    go_sleep("R7 bounce");
    @(negedge clk);
    wake_n = 1'b0;
    repeat (20) @(negedge clk);
    wake_n = 1'b1;
    repeat (100) @(negedge clk);
    chk("R7 still asleep", {31'b0, pwr_en}, 32'h0);
    rd_chk("R7 cmd reads 1", 6'h20, 32'h1);
    wake_measure("R7 restart", 64, 32);
  endtask

  task automatic t_default;
    wr(6'h24, 32'd3264);
    wr(6'h28, 32'd1952);
    go_sleep("R6 default");
    wake_measure("R6 default", 3264, 1952);
  endtask

  initial begin
    #1_500_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_mid();
    t_zero();
    t_bounce();
    t_default();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule